// File: doc/BRIEF.md
# Reloadable Down-Counting Interval Timer

This block is a bank of 32-bit interval timers on a simple register bus. Each channel counts down from a programmed start value at a rate picked by a prescaler. When the counter passes zero it raises an underflow flag. A channel in periodic mode then reloads and keeps running; a channel in one-shot mode stops. The underflow flag, gated by an interrupt enable, drives a level interrupt line. An output level toggles on every underflow.

Software starts a channel by setting trigger, count enable, and the mode and interrupt bits in one control write. It acknowledges an interrupt by reading the control word, clearing the flag bit and writing the word back. A channel preloaded with all ones and left free-running serves as an elapsed-time source: the bitwise inverse of its count grows by one per tick. The channels sit side by side at a fixed 16-byte stride.

Top module: `tmr_bank`

## Requirements
- R1: After reset, every register of every channel reads 0, and `irq_o` and `level_o` are low.
- R2: Channel n occupies bytes n*0x10 to n*0x10+0xF. In that range the control word is at offset 0x0, the live count at 0x4, the primary reload at 0x8 and a secondary reload (storage only) at 0xC. The count and both reloads read back what was written, and each channel is independent.
- R3: Control bits [7:6] select the tick rate: one tick every 2<<(2*sel) clocks, so value 0 ticks at half the clock rate.
- R4: Writing 1 to control bit 0 (trigger) loads the primary reload into the counter on the next tick at which count enable is set. Bit 0 always reads back as 0.
- R5: While count enable (bit 1) is set, each tick decrements the count by one. A tick that finds the count at 0 is an underflow, so a start value R gives an underflow period of (R+1) ticks.
- R6: With reload mode (bit 4) set, an underflow reloads the primary reload value and counting continues. Start values from 15 to 0xFFFFFFFF are supported.
- R7: With reload mode clear, an underflow clears count enable, and the count holds at 0.
- R8: An underflow sets the flag at bit 2. `irq_o[n]` is high exactly while that flag and interrupt enable (bit 3) are both set.
- R9: A control write with bit 2 = 0 clears the flag, and a write with bit 2 = 1 leaves it unchanged. All other writable fields take the written values.
- R10: Writing 0 to the control word stops the counter, drops the interrupt line and cancels a pending trigger.
- R11: Control bit 5 toggles on each underflow and drives `level_o[n]`.
- R12: If an underflow and a control write fall in the same cycle, the flag is set regardless of the written bit 2, and bit 5 becomes the written value inverted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address (channel in the upper bits, word in [3:2]) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| irq_o | output | NCH | Level interrupt, one bit per channel |
| level_o | output | NCH | Toggling output level, one bit per channel |

## Verification
The collision that matters is an underflow landing in the same clock as the software write that acknowledges the previous one. The bench runs a periodic channel at the half-rate prescaler and polls the count until it first reads 0. This places the next tick exactly two clocks ahead. The bench times the read-modify-write clear to commit on that edge. It then judges the result: the flag must still read 1 and the level must be the inverse of the written bit. A control run issues the same clear away from any underflow and expects the flag to read 0.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int DATA_W = 32;
  localparam int PSEL_W = 2;
  localparam int NSEL   = 1 << PSEL_W;
  localparam int PRE_W  = 2 * (NSEL - 1) + 1;

  localparam int B_TRG  = 0;
  localparam int B_CNTE = 1;
  localparam int B_UF   = 2;
  localparam int B_INTE = 3;
  localparam int B_RELD = 4;
  localparam int B_OUTL = 5;
  localparam int B_PSEL = 6;

  typedef enum logic [1:0] {
    REG_CTRL  = 2'd0,
    REG_COUNT = 2'd1,
    REG_RLD1  = 2'd2,
    REG_RLD2  = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic [PSEL_W-1:0] psel;
    logic              outl;
    logic              reld;
    logic              inte;
    logic              uf;
    logic              cnte;
  } ctrl_t;

  // clocks per prescaled tick
  function automatic int unsigned tick_div(input logic [PSEL_W-1:0] sel);
    return 32'd2 << (2 * sel);
  endfunction

  function automatic logic [DATA_W-1:0] pack_ctrl(input ctrl_t c);
    logic [DATA_W-1:0] v;
    v = '0;
    v[B_CNTE] = c.cnte;
    v[B_UF]   = c.uf;
    v[B_INTE] = c.inte;
    v[B_RELD] = c.reld;
    v[B_OUTL] = c.outl;
    v[B_PSEL +: PSEL_W] = c.psel;
    return v;
  endfunction

  function automatic logic [DATA_W-1:0] count_step(input logic [DATA_W-1:0] c);
    return c - DATA_W'(1);
  endfunction
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
  import tmr_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  output logic [NSEL-1:0] tick_o
);
  logic [PRE_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt + PRE_W'(1);
  end

  // rate s: all low 2*s+1 bits set -> one pulse every 2<<(2*s) clocks
  for (genvar s = 0; s < NSEL; s++) begin : g_rate
    assign tick_o[s] = &cnt[2*s:0];
  end
endmodule

// File: rtl/tmr_down_core.sv
module tmr_down_core
  import tmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              cnte,
  input  logic              reld,
  input  logic              load,
  input  logic              cnt_wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] rld1,
  output logic [DATA_W-1:0] count,
  output logic              uf_evt
);
  logic at_zero;

  assign at_zero = (count == '0);
  assign uf_evt  = tick && cnte && !load && at_zero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else if (cnt_wr) begin
      count <= wdata;
    end else if (load) begin
      count <= rld1;
    end else if (tick && cnte) begin
      if (at_zero) count <= reld ? rld1 : '0;
      else         count <= count_step(count);
    end
  end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        reg_sel,
  input  logic [DATA_W-1:0] wdata,
  input  logic [NSEL-1:0]   tick_vec,
  output logic [DATA_W-1:0] rdata,
  output logic              irq,
  output logic              level,
  output logic              mon_tick,
  output logic              mon_load,
  output logic              mon_uf_evt,
  output logic              mon_ctrl_wr,
  output logic              mon_cnt_wr,
  output logic              mon_cnte,
  output logic              mon_reld,
  output logic              mon_uf,
  output logic [DATA_W-1:0] mon_count,
  output logic [DATA_W-1:0] mon_rld1
);
  ctrl_t             ctrl;
  logic              pend;
  logic [DATA_W-1:0] rld1, rld2, count;
  logic              tick, load, uf_evt, ctrl_wr, cnt_wr;
  reg_sel_e          rsel;

  assign rsel    = reg_sel_e'(reg_sel);
  assign ctrl_wr = wr_en && (rsel == REG_CTRL);
  assign cnt_wr  = wr_en && (rsel == REG_COUNT);
  assign tick    = tick_vec[ctrl.psel];
  assign load    = tick && pend && ctrl.cnte;

  tmr_down_core u_core (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick),
    .cnte   (ctrl.cnte),
    .reld   (ctrl.reld),
    .load   (load),
    .cnt_wr (cnt_wr),
    .wdata  (wdata),
    .rld1   (rld1),
    .count  (count),
    .uf_evt (uf_evt)
  );

  // control word: a hardware underflow is merged into a same-cycle write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0;
    end else if (ctrl_wr) begin
      ctrl.psel <= wdata[B_PSEL +: PSEL_W];
      ctrl.inte <= wdata[B_INTE];
      ctrl.reld <= wdata[B_RELD];
      ctrl.cnte <= wdata[B_CNTE];
      ctrl.outl <= wdata[B_OUTL] ^ uf_evt;
      ctrl.uf   <= (ctrl.uf && wdata[B_UF]) || uf_evt;
    end else if (uf_evt) begin
      ctrl.uf   <= 1'b1;
      ctrl.outl <= ~ctrl.outl;
      if (!ctrl.reld) ctrl.cnte <= 1'b0;
    end
  end

  // pending trigger, consumed on the next enabled tick
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          pend <= 1'b0;
    else if (ctrl_wr && wdata[B_TRG])    pend <= 1'b1;
    else if (ctrl_wr && !wdata[B_CNTE])  pend <= 1'b0;
    else if (load)                       pend <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rld1 <= '0;
      rld2 <= '0;
    end else if (wr_en) begin
      if (rsel == REG_RLD1) rld1 <= wdata;
      if (rsel == REG_RLD2) rld2 <= wdata;
    end
  end

  always_comb begin
    unique case (rsel)
      REG_CTRL:  rdata = pack_ctrl(ctrl);
      REG_COUNT: rdata = count;
      REG_RLD1:  rdata = rld1;
      REG_RLD2:  rdata = rld2;
      default:   rdata = '0;
    endcase
  end

  assign irq   = ctrl.uf && ctrl.inte;
  assign level = ctrl.outl;

  assign mon_tick    = tick;
  assign mon_load    = load;
  assign mon_uf_evt  = uf_evt;
  assign mon_ctrl_wr = ctrl_wr;
  assign mon_cnt_wr  = cnt_wr;
  assign mon_cnte    = ctrl.cnte;
  assign mon_reld    = ctrl.reld;
  assign mon_uf      = ctrl.uf;
  assign mon_count   = count;
  assign mon_rld1    = rld1;
endmodule

// File: rtl/tmr_bank.sv
module tmr_bank
  import tmr_pkg::*;
#(
  parameter  int NCH    = 2,
  localparam int CH_W   = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int ADDR_W = CH_W + 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NCH-1:0]    irq_o,
  output logic [NCH-1:0]    level_o
);
  logic [NSEL-1:0]              tick_vec;
  logic [CH_W-1:0]              ch_idx;
  logic [1:0]                   reg_sel;
  logic [NCH-1:0][DATA_W-1:0]   ch_rdata;

  logic [NCH-1:0]               mon_tick, mon_load, mon_uf_evt, mon_ctrl_wr;
  logic [NCH-1:0]               mon_cnt_wr, mon_cnte, mon_reld, mon_uf;
  logic [NCH-1:0][DATA_W-1:0]   mon_count, mon_rld1;

  assign ch_idx  = bus_addr[ADDR_W-1:4];
  assign reg_sel = bus_addr[3:2];

  tmr_prescaler u_pre (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_o (tick_vec)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic wr_en;
    assign wr_en = bus_sel && bus_wr && (ch_idx == CH_W'(i));

    tmr_channel u_ch (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (wr_en),
      .reg_sel     (reg_sel),
      .wdata       (bus_wdata),
      .tick_vec    (tick_vec),
      .rdata       (ch_rdata[i]),
      .irq         (irq_o[i]),
      .level       (level_o[i]),
      .mon_tick    (mon_tick[i]),
      .mon_load    (mon_load[i]),
      .mon_uf_evt  (mon_uf_evt[i]),
      .mon_ctrl_wr (mon_ctrl_wr[i]),
      .mon_cnt_wr  (mon_cnt_wr[i]),
      .mon_cnte    (mon_cnte[i]),
      .mon_reld    (mon_reld[i]),
      .mon_uf      (mon_uf[i]),
      .mon_count   (mon_count[i]),
      .mon_rld1    (mon_rld1[i])
    );
  end

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < NCH; i++) begin
      if (bus_sel && (ch_idx == CH_W'(i))) bus_rdata = ch_rdata[i];
    end
  end
endmodule

// File: rtl/tmr_bank_chk.sv
module tmr_bank_chk
  import tmr_pkg::*;
#(
  parameter int NCH    = 2,
  parameter int ADDR_W = 5
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      bus_sel,
  input logic [ADDR_W-1:0]         bus_addr,
  input logic [DATA_W-1:0]         bus_wdata,
  input logic [DATA_W-1:0]         bus_rdata,
  input logic [NCH-1:0]            irq_o,
  input logic [NCH-1:0]            level_o,
  input logic [NCH-1:0]            mon_tick,
  input logic [NCH-1:0]            mon_load,
  input logic [NCH-1:0]            mon_uf_evt,
  input logic [NCH-1:0]            mon_ctrl_wr,
  input logic [NCH-1:0]            mon_cnt_wr,
  input logic [NCH-1:0]            mon_cnte,
  input logic [NCH-1:0]            mon_reld,
  input logic [NCH-1:0]            mon_uf,
  input logic [NCH-1:0][DATA_W-1:0] mon_count,
  input logic [NCH-1:0][DATA_W-1:0] mon_rld1
);
  // R4
  trig_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_addr[3:2] == 2'd0) |-> !bus_rdata[B_TRG]);

  for (genvar i = 0; i < NCH; i++) begin : g_chk
    // R5
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mon_tick[i] && mon_cnte[i] && !mon_load[i] && !mon_cnt_wr[i] && mon_count[i] != '0)
      |=> mon_count[i] == $past(mon_count[i]) - 32'd1);

    // R6
    periodic_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mon_uf_evt[i] && mon_reld[i] && !mon_cnt_wr[i]) |=> mon_count[i] == $past(mon_rld1[i]));

    // R7
    oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mon_uf_evt[i] && !mon_reld[i] && !mon_ctrl_wr[i]) |=> !mon_cnte[i]);

    // R8 R12
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mon_uf_evt[i] |=> mon_uf[i]);

    // R8
    irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_o[i]) |-> mon_uf[i]);

    // R10
    stop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mon_ctrl_wr[i] && bus_wdata == '0) |=> (!irq_o[i] && !mon_cnte[i]));

    // R11
    level_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mon_uf_evt[i] && !mon_ctrl_wr[i]) |=> level_o[i] != $past(level_o[i]));
  end
endmodule

bind tmr_bank tmr_bank_chk #(.NCH(NCH), .ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_sel     (bus_sel),
  .bus_addr    (bus_addr),
  .bus_wdata   (bus_wdata),
  .bus_rdata   (bus_rdata),
  .irq_o       (irq_o),
  .level_o     (level_o),
  .mon_tick    (mon_tick),
  .mon_load    (mon_load),
  .mon_uf_evt  (mon_uf_evt),
  .mon_ctrl_wr (mon_ctrl_wr),
  .mon_cnt_wr  (mon_cnt_wr),
  .mon_cnte    (mon_cnte),
  .mon_reld    (mon_reld),
  .mon_uf      (mon_uf),
  .mon_count   (mon_count),
  .mon_rld1    (mon_rld1)
);

// File: tb/tmr_bank_test.sv
module tmr_bank_test;
  localparam int NCH = 2;
  localparam int AW  = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_sel = 1'b0;
  logic          bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NCH-1:0] irq_o, level_o;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  tmr_bank #(.NCH(NCH)) uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o), .level_o(level_o)
  );

  // word offsets used by the bench: ctrl 0, count 1, reload1 2, reload2 3
  function automatic logic [AW-1:0] ad(input int ch, input int w);
    return AW'(ch * 16 + w * 4);
  endfunction

  function automatic int period_clks(input int rld, input int sel);
    return (rld + 1) * (2 << (2 * sel));
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input int ch, input int w, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = ad(ch, w); bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input int ch, input int w, output logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = ad(ch, w);
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic wait_irq(input int ch, input int lim, output bit seen);
    seen = 1'b0;
    for (int k = 0; k < lim && !seen; k++) begin
      @(negedge clk);
      if (irq_o[ch]) seen = 1'b1;
    end
  endtask

  // clocks between two successive level changes
  task automatic measure(input int ch, output int n);
    logic l;
    int k;
    l = level_o[ch];
    k = 0;
    while (level_o[ch] == l && k < 5000) begin @(negedge clk); k++; end
    l = level_o[ch];
    n = 0;
    while (level_o[ch] == l && n < 5000) begin @(negedge clk); n++; end
  endtask

  task automatic t_reset;
    logic [31:0] v;
    for (int ch = 0; ch < NCH; ch++)
      for (int w = 0; w < 4; w++) begin
        rd(ch, w, v);
        check(v == 0, "R1 register reset", v, 0);
      end
    check(irq_o == 0 && level_o == 0, "R1 outputs reset", {irq_o, level_o}, 0);
  endtask

  task automatic t_map;
    logic [31:0] v;
    wr(0, 1, 32'h1111_0001); wr(0, 2, 32'h2222_0002); wr(0, 3, 32'h3333_0003);
    wr(1, 1, 32'hAAAA_0004); wr(1, 2, 32'hBBBB_0005); wr(1, 3, 32'hCCCC_0006);
    rd(0, 1, v); check(v == 32'h1111_0001, "R2 ch0 count", v, 32'h1111_0001);
    rd(0, 2, v); check(v == 32'h2222_0002, "R2 ch0 reload1", v, 32'h2222_0002);
    rd(0, 3, v); check(v == 32'h3333_0003, "R2 ch0 reload2", v, 32'h3333_0003);
    rd(1, 1, v); check(v == 32'hAAAA_0004, "R2 ch1 count", v, 32'hAAAA_0004);
    rd(1, 2, v); check(v == 32'hBBBB_0005, "R2 ch1 reload1", v, 32'hBBBB_0005);
    rd(1, 3, v); check(v == 32'hCCCC_0006, "R2 ch1 reload2", v, 32'hCCCC_0006);
  endtask

  task automatic t_periodic_min;
    int n;
    logic [31:0] v;
    wr(0, 0, 0); wr(0, 2, 15);
    wr(0, 0, 32'h1B);
    rd(0, 0, v);
    check(v[0] == 1'b0, "R4 trigger reads zero", v, v & ~32'h1);
    measure(0, n);
    check(n == period_clks(15, 0), "R5 R6 R3 period reload 15 sel 0", n, period_clks(15, 0));
    measure(0, n);
    check(n == period_clks(15, 0), "R6 R11 repeated period", n, period_clks(15, 0));
    check(irq_o[0] == 1'b1, "R8 irq after underflow", irq_o, 1);
    wr(0, 0, 0);
  endtask

  task automatic t_prescale;
    int n;
    wr(0, 2, 20);
    wr(0, 0, 32'h53);
    measure(0, n);
    check(n == period_clks(20, 1), "R3 period sel 1", n, period_clks(20, 1));
    wr(0, 0, 0);
  endtask

  task automatic t_oneshot;
    bit seen;
    logic [31:0] v;
    logic l0;
    wr(1, 0, 0); wr(1, 2, 30);
    l0 = level_o[1];
    wr(1, 0, 32'h0B);
    wait_irq(1, 400, seen);
    check(seen, "R8 one-shot irq", seen, 1);
    rd(1, 0, v);
    check(v[1] == 1'b0 && v[2] == 1'b1, "R7 enable cleared, flag set", v, 32'h0C);
    check(level_o[1] == ~l0, "R11 level toggled once", level_o[1], ~l0);
    idle(150);
    rd(1, 1, v);
    check(v == 0, "R7 count holds zero", v, 0);
    check(level_o[1] == ~l0, "R7 no further underflow", level_o[1], ~l0);
    wr(1, 0, 0);
  endtask

  task automatic t_clear;
    bit seen;
    logic [31:0] v, v2;
    wr(0, 2, 15);
    wr(0, 0, 32'h1B);
    wait_irq(0, 200, seen);
    rd(0, 0, v);
    check((v & 32'h1E) == 32'h1E, "R8 flag and fields set", v, v | 32'h1E);
    wr(0, 0, v & ~32'h4);
    rd(0, 0, v2);
    check((v2 & 32'h1E) == 32'h1A, "R9 flag cleared, fields kept", v2, 32'h1A);
    check(irq_o[0] == 1'b0, "R9 irq drops", irq_o, 0);
    wr(0, 0, v2 | 32'h4);
    rd(0, 0, v2);
    check(v2[2] == 1'b0, "R9 writing one leaves flag clear", v2, v2 & ~32'h4);
    wr(0, 0, 0);
  endtask

  task automatic t_no_inte;
    logic [31:0] v;
    wr(0, 2, 15);
    wr(0, 0, 32'h13);
    idle(80);
    rd(0, 0, v);
    check(v[2] == 1'b1, "R8 flag without enable", v, v | 32'h4);
    check(irq_o[0] == 1'b0, "R8 irq masked", irq_o, 0);
    wr(0, 0, 0);
  endtask

  task automatic t_stop;
    logic [31:0] a, b;
    wr(0, 2, 1000);
    wr(0, 0, 32'h1B);
    idle(40);
    wr(0, 0, 0);
    rd(0, 1, a);
    idle(50);
    rd(0, 1, b);
    check(a == b, "R10 count frozen", b, a);
    check(irq_o[0] == 1'b0, "R10 irq off", irq_o, 0);
    // pending trigger cancelled by a zero write
    wr(0, 1, 5);
    wr(0, 0, 32'h01);
    wr(0, 0, 0);
    wr(0, 0, 32'h02);
    idle(30);
    rd(0, 1, a);
    check(a == 0, "R10 cancelled trigger, count ran down", a, 0);
    rd(0, 0, b);
    check(b[2] == 1'b1 && b[1] == 1'b0, "R7 one-shot end after plain enable", b, 32'h4);
    wr(0, 0, 0);
  endtask

  task automatic t_retrigger;
    logic [31:0] v;
    bit hit;
    wr(0, 2, 1000);
    wr(0, 0, 32'h13);
    idle(400);
    rd(0, 1, v);
    check(v < 1000, "R5 counted down", v, 800);
    wr(0, 0, 32'h13);
    hit = 0;
    for (int k = 0; k < 3; k++) begin
      rd(0, 1, v);
      if (v == 1000) hit = 1;
      @(negedge clk);
    end
    check(hit, "R4 trigger reloads", v, 1000);
    wr(0, 0, 0);
  endtask

  task automatic t_freerun;
    logic [31:0] a, b;
    wr(1, 0, 0);
    wr(1, 1, 32'hFFFF_FFFF); wr(1, 2, 32'hFFFF_FFFF);
    wr(1, 0, 32'h13);
    idle(4);
    rd(1, 1, a);
    idle(200);
    rd(1, 1, b);
    check((~b) - (~a) == 100, "R6 full-range elapsed", (~b) - (~a), 100);
    wr(1, 0, 0);
  endtask

  task automatic t_collide;
    bit seen;
    logic [31:0] v, c, r;
    wr(0, 2, 15);
    wr(0, 0, 32'h1B);
    wait_irq(0, 200, seen);
    rd(0, 0, v);
    c = 32'hFFFF_FFFF;
    for (int k = 0; k < 100 && c != 0; k++) begin
      @(negedge clk);
      rd(0, 1, c);
    end
    // tick edge that found count 1 just passed; next tick is two edges on
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = ad(0, 0); bus_wdata = v & ~32'h4;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
    rd(0, 0, r);
    check(r[2] == 1'b1, "R12 flag survives same-cycle clear", r, r | 32'h4);
    check(r[5] == ~v[5], "R12 level inverted from written", r[5], ~v[5]);
    wr(0, 0, 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_map();
    t_periodic_min();
    t_prescale();
    t_oneshot();
    t_clear();
    t_no_inte();
    t_stop();
    t_retrigger();
    t_freerun();
    t_collide();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(8 * 150000);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule